// File: doc/BRIEF.md
# Hashed Page Table Walker

This block is a sequential search engine for a hashed page table kept in memory. It is given a segment register value and a 32-bit effective address. From the virtual segment ID and the page index it forms a hash and a compare tag. It then reads the eight 8-byte entries of the primary group one after another, and if none of them matches, the eight entries of the secondary group. On a hit it returns both words of the entry and the entry's byte offset from the table base.

Before it answers a hit, the walker sets the referenced bit and, for a store, the changed bit. Each of these updates is a single-byte write into the entry. When a load finds the changed bit clear, the walker leaves that bit alone and reports that write permission must be withheld for now. The walker does not judge permissions and does not report faults. The unit that owns the request does that from the returned words.

Memory is reached through a simple port. A request is held with a stable address until a one-cycle acknowledge comes back, and read data arrives with that acknowledge. Reads are 32-bit big-endian words and writes are single bytes. The table base and the hash mask are captured when a request is accepted.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: VSID is segreg[23:0] and the page index is ea[27:12]. The primary hash is the VSID XORed with the page index (zero-extended), truncated to the mask width. The group offset is (hash AND cfg_mask) shifted left by 6. Entry i of a group lies at cfg_base OR group offset OR 8*i, and every memory address has the upper bits of cfg_base.
- R3: The secondary group uses the bitwise complement of the hash in place of the hash. It is searched only after all 8 primary entries have failed to match.
- R4: An entry matches only when all of these hold: word0[31] (valid) is 1, word0[6] (secondary flag) equals the pass (0 for primary, 1 for secondary), word0[30:7] equals the VSID, and word0[5:0] equals the page index bits [15:10].
- R5: Entries are examined in ascending address order, and the first match ends the search. For each entry, word0 at offset 0 is read, and only after that read completes is word1 at offset 4 read. A hit at entry i costs 2*(i+1) reads in the primary pass, or 16+2*(i+1) reads in the secondary pass.
- R6: A hit gives rsp_hit=1 with rsp_word0 and rsp_word1 as read from memory, before any update. rsp_offset is the entry's byte offset from cfg_base.
- R7: When word1[8] (referenced) is 0, the byte at entry offset 6 is written with word1[15:8] OR 0x01 before the response.
- R8: When word1[7] (changed) is 0 and the request is a store, the byte at entry offset 7 is written with word1[7:0] OR 0x80. This write comes after any referenced-bit write and before the response.
- R9: rsp_no_write is 1 exactly when a hit has word1[7]=0 and the request is a load. In that case no write to offset 7 is made.
- R10: A hit whose word1 already has the needed bits set performs no memory write.
- R11: A miss is answered with rsp_hit=0 and rsp_no_write=0, only after all 32 reads of both groups, and with no writes.
- R12: A request is accepted only while req_ready is 1. Each accepted request yields exactly one single-cycle rsp_valid pulse, after which req_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Table base address, captured at request accept |
| cfg_mask | input | HASH_W | Hash mask, captured at request accept |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_segreg | input | 32 | Segment register value (VSID in [23:0]) |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Matching entry found |
| rsp_word0 | output | 32 | Entry word 0 (valid on hit) |
| rsp_word1 | output | 32 | Entry word 1 as read (valid on hit) |
| rsp_offset | output | 32 | Entry byte offset from base (valid on hit) |
| rsp_no_write | output | 1 | Write permission to be withheld |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | One-cycle request completion |
| mem_rdata | input | 32 | Read word, valid with mem_ack |

## Verification
The hardest situation to reach is a hit in the secondary group. It needs the primary group to hold entries that look like matches but each fail on exactly one field: the valid bit, the secondary flag or the tag. The bench builds this by computing both group addresses itself and planting such near-miss entries, then the real entry, in its byte-wide memory model. A reference search over that same image predicts the read count, the write count and the final bytes 6 and 7 of the entry. The memory answers with a different wait per case, so that ordering and the holding of requests are exercised under back-pressure.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

    localparam int VSID_W      = 24;
    localparam int PGIDX_W     = 16;
    localparam int API_W       = 6;
    localparam int DEF_HASH_W  = 19;
    localparam int GRP_ENTRIES = 8;
    localparam int ENTRY_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_SET_R,
        ST_SET_C,
        ST_RESP
    } walk_state_e;

    // Layout of entry word 0
    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              second;
        logic [API_W-1:0]  api;
    } pte_hi_t;

    typedef struct packed {
        logic [VSID_W-1:0] vsid;
        logic [API_W-1:0]  api;
    } cmp_tag_t;

    function automatic logic ref_clear(input logic [31:0] w1);
        return !w1[8];
    endfunction

    function automatic logic chg_clear(input logic [31:0] w1);
        return !w1[7];
    endfunction

    function automatic logic [7:0] ref_byte(input logic [31:0] w1);
        return w1[15:8] | 8'h01;
    endfunction

    function automatic logic [7:0] chg_byte(input logic [31:0] w1);
        return w1[7:0] | 8'h80;
    endfunction

endpackage

// File: rtl/hptw_hash.sv
module hptw_hash
    import hptw_pkg::*;
#(
    parameter int HASH_W    = DEF_HASH_W,
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0]  vsid,
    input  logic [PGIDX_W-1:0] pgidx,
    input  logic [HASH_W-1:0]  mask,
    input  logic               second,
    output logic [31:0]        grp_off,
    output cmp_tag_t           tag
);
    logic [HASH_W-1:0] hash;
    logic [HASH_W-1:0] hsel;

    always_comb begin
        hash    = vsid[HASH_W-1:0] ^ HASH_W'(pgidx);
        hsel    = second ? ~hash : hash;
        grp_off = 32'(hsel & mask) << GRP_SHIFT;
        tag     = '{vsid: vsid, api: pgidx[PGIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hptw_match.sv
module hptw_match
    import hptw_pkg::*;
(
    input  logic [31:0] word0,
    input  cmp_tag_t    tag,
    input  logic        second,
    output logic        hit
);
    pte_hi_t hi;

    always_comb begin
        hi  = pte_hi_t'(word0);
        hit = hi.valid && (hi.second == second) &&
              (hi.vsid == tag.vsid) && (hi.api == tag.api);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
#(
    parameter int HASH_W = DEF_HASH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_base,
    input  logic [HASH_W-1:0] cfg_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_segreg,
    input  logic [31:0]       req_ea,
    input  logic              req_store,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_word0,
    output logic [31:0]       rsp_word1,
    output logic [31:0]       rsp_offset,
    output logic              rsp_no_write,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int IDX_W       = $clog2(GRP_ENTRIES);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT   = $clog2(GRP_ENTRIES * ENTRY_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GRP_ENTRIES - 1);

    walk_state_e        state;
    logic [VSID_W-1:0]  vsid_q;
    logic [PGIDX_W-1:0] pg_q;
    logic [HASH_W-1:0]  mask_q;
    logic [31:0]        base_q;
    logic               store_q;
    logic               pass_q;
    logic [IDX_W-1:0]   idx_q;
    logic [31:0]        w0_q, w1_q, off_q;
    logic               hit_q, nowr_q;

    logic [31:0]        grp_off, entry_off;
    cmp_tag_t           tag;
    logic               is_match;

    logic unused_inputs;
    assign unused_inputs = ^{req_segreg[31:VSID_W], req_ea[31:28], req_ea[11:0]};

    hptw_hash #(.HASH_W(HASH_W), .GRP_SHIFT(GRP_SHIFT)) u_hash (
        .vsid    (vsid_q),
        .pgidx   (pg_q),
        .mask    (mask_q),
        .second  (pass_q),
        .grp_off (grp_off),
        .tag     (tag)
    );

    hptw_match u_match (
        .word0  (w0_q),
        .tag    (tag),
        .second (pass_q),
        .hit    (is_match)
    );

    assign entry_off = grp_off | (32'(idx_q) << ENTRY_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            vsid_q  <= '0;
            pg_q    <= '0;
            mask_q  <= '0;
            base_q  <= '0;
            store_q <= 1'b0;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            off_q   <= '0;
            hit_q   <= 1'b0;
            nowr_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    vsid_q  <= req_segreg[VSID_W-1:0];
                    pg_q    <= req_ea[27:12];
                    mask_q  <= cfg_mask;
                    base_q  <= cfg_base;
                    store_q <= req_store;
                    pass_q  <= 1'b0;
                    idx_q   <= '0;
                    hit_q   <= 1'b0;
                    nowr_q  <= 1'b0;
                    state   <= ST_RD0;
                end
                ST_RD0: if (mem_ack) begin
                    w0_q  <= mem_rdata;
                    state <= ST_RD1;
                end
                ST_RD1: if (mem_ack) begin
                    w1_q <= mem_rdata;
                    if (is_match) begin
                        hit_q  <= 1'b1;
                        off_q  <= entry_off;
                        nowr_q <= chg_clear(mem_rdata) && !store_q;
                        if (ref_clear(mem_rdata))
                            state <= ST_SET_R;
                        else if (chg_clear(mem_rdata) && store_q)
                            state <= ST_SET_C;
                        else
                            state <= ST_RESP;
                    end else if (idx_q == LAST_IDX) begin
                        idx_q <= '0;
                        if (!pass_q) begin
                            pass_q <= 1'b1;
                            state  <= ST_RD0;
                        end else begin
                            state  <= ST_RESP;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        state <= ST_RD0;
                    end
                end
                ST_SET_R: if (mem_ack) begin
                    state <= (chg_clear(w1_q) && store_q) ? ST_SET_C : ST_RESP;
                end
                ST_SET_C: if (mem_ack) state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = base_q | entry_off;
        mem_wdata = 8'h00;
        case (state)
            ST_RD0:   mem_addr = base_q | entry_off;
            ST_RD1:   mem_addr = base_q | entry_off | 32'd4;
            ST_SET_R: begin
                mem_we    = 1'b1;
                mem_addr  = base_q | off_q | 32'd6;
                mem_wdata = ref_byte(w1_q);
            end
            ST_SET_C: begin
                mem_we    = 1'b1;
                mem_addr  = base_q | off_q | 32'd7;
                mem_wdata = chg_byte(w1_q);
            end
            default:  mem_req = 1'b0;
        endcase
    end

    assign req_ready    = (state == ST_IDLE);
    assign rsp_valid    = (state == ST_RESP);
    assign rsp_hit      = hit_q;
    assign rsp_word0    = w0_q;
    assign rsp_word1    = w1_q;
    assign rsp_offset   = off_q;
    assign rsp_no_write = nowr_q;

    // Word 1 of an entry is only fetched right after its word 0
    p_w1_after_w0_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD1 && $past(state) != ST_RD1) |-> ($past(state) == ST_RD0));

    p_hold_req_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_ref_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_addr[0]) |-> (mem_wdata[0] && mem_addr[2:0] == 3'd6));

    p_chg_store_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr[0]) |-> (store_q && mem_wdata[7]));

    p_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_no_write) |-> (rsp_hit && !rsp_word1[7] && !store_q));

    p_miss_late_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> pass_q);

    p_single_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/hpt_walker_test.sv
`timescale 1ns/1ps
module hpt_walker_test;
    import hptw_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] base;
    logic [18:0] mask;
    logic        req_valid, req_store;
    logic [31:0] req_segreg, req_ea;
    logic        req_ready, rsp_valid, rsp_hit, rsp_no_write;
    logic [31:0] rsp_word0, rsp_word1, rsp_offset;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic [7:0]  mem_wdata;

    always #10 clk = ~clk;

    hpt_walker uut (
        .clk(clk), .rst(rst), .cfg_base(base), .cfg_mask(mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_segreg(req_segreg),
        .req_ea(req_ea), .req_store(req_store), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_word0(rsp_word0), .rsp_word1(rsp_word1),
        .rsp_offset(rsp_offset), .rsp_no_write(rsp_no_write),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:8191];
    int          lat = 0;
    int          wcnt = 0;
    int          n_rd, n_wr;
    bit          order_bad, addr_bad;
    logic [31:0] last_rd;

    function automatic logic [31:0] rd32(input logic [12:0] a);
        return {mem[a], mem[a + 13'd1], mem[a + 13'd2], mem[a + 13'd3]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt = 0;
        end else begin
            if (req_valid && req_ready) begin
                n_rd = 0; n_wr = 0; order_bad = 0; addr_bad = 0; last_rd = '1;
            end
            if (mem_req && !mem_ack) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    mem_ack <= 1'b1;
                    if (mem_addr[31:13] != base[31:13]) addr_bad = 1;
                    if (mem_we) begin
                        mem[mem_addr[12:0]] = mem_wdata;
                        n_wr++;
                    end else begin
                        mem_rdata <= rd32(mem_addr[12:0]);
                        n_rd++;
                        if (mem_addr[2] && last_rd != mem_addr - 32'd4) order_bad = 1;
                        if (mem_addr[1:0] != 2'b00) order_bad = 1;
                        last_rd = mem_addr;
                    end
                end else begin
                    wcnt++;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // ---------------- bench-side model ----------------
    typedef struct {
        bit          hit;
        logic [31:0] w0, w1, off;
        bit          nw;
        int          nrd, nwr;
        logic [7:0]  b6, b7;
    } exp_t;

    exp_t sb[$];
    int   done_cnt = 0;

    function automatic logic [31:0] grp_of(input logic [31:0] seg, input logic [31:0] ea,
                                           input bit pass);
        logic [18:0] h;
        h = seg[18:0] ^ {3'b000, ea[27:12]};
        if (pass) h = ~h;
        return {7'd0, h & mask, 6'd0};
    endfunction

    function automatic logic [31:0] ent_addr(input logic [31:0] seg, input logic [31:0] ea,
                                             input bit pass, input int i);
        return base | grp_of(seg, ea, pass) | (32'(i) << 3);
    endfunction

    function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] vs,
                                          input bit sec, input logic [5:0] api);
        return {v, vs, sec, api};
    endfunction

    function automatic exp_t model(input logic [31:0] seg, input logic [31:0] ea, input bit st);
        exp_t e;
        logic [31:0] a, w0, w1;
        e = '{hit: 0, w0: 0, w1: 0, off: 0, nw: 0, nrd: 0, nwr: 0, b6: 0, b7: 0};
        for (int p = 0; p < 2 && !e.hit; p++) begin
            for (int i = 0; i < 8 && !e.hit; i++) begin
                a  = ent_addr(seg, ea, p[0], i);
                w0 = rd32(a[12:0]);
                w1 = rd32(a[12:0] + 13'd4);
                e.nrd += 2;
                if (w0[31] && w0[6] == p[0] && w0[30:7] == seg[23:0] && w0[5:0] == ea[27:22]) begin
                    e.hit = 1; e.w0 = w0; e.w1 = w1; e.off = a & ~base;
                    e.b6 = w1[15:8]; e.b7 = w1[7:0];
                    if (!w1[8]) begin e.nwr++; e.b6 = w1[15:8] | 8'h01; end
                    if (!w1[7] && st) begin e.nwr++; e.b7 = w1[7:0] | 8'h80; end
                    e.nw = !w1[7] && !st;
                end
            end
        end
        return e;
    endfunction

    // ---------------- monitor ----------------
    always @(negedge clk) begin : monitor
        exp_t e;
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                e = sb.pop_front();
                chk("R6 hit flag", 32'(rsp_hit), 32'(e.hit));
                chk("R9 no_write", 32'(rsp_no_write), 32'(e.nw));
                chk(e.hit ? "R5 read count" : "R11 read count", 32'(n_rd), 32'(e.nrd));
                chk(e.hit ? "R10 write count" : "R11 write count", 32'(n_wr), 32'(e.nwr));
                chk("R5 word order", 32'(order_bad), 32'd0);
                chk("R2 address base bits", 32'(addr_bad), 32'd0);
                if (e.hit) begin
                    chk("R6 word0", rsp_word0, e.w0);
                    chk("R6 word1", rsp_word1, e.w1);
                    chk("R2 offset", rsp_offset, e.off);
                end
            end
            done_cnt++;
        end
    end

    // ---------------- driver ----------------
    task automatic clr();
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        logic [12:0] b;
        b = a[12:0];
        for (int k = 0; k < 4; k++) begin
            mem[b + 13'(k)]     = w0[31 - 8*k -: 8];
            mem[b + 13'(4 + k)] = w1[31 - 8*k -: 8];
        end
    endtask

    task automatic run(input logic [31:0] seg, input logic [31:0] ea, input bit st, input int l);
        exp_t e;
        int prev;
        logic [12:0] a;
        e = model(seg, ea, st);
        sb.push_back(e);
        lat = l;
        prev = done_cnt;
        @(negedge clk);
        req_segreg = seg; req_ea = ea; req_store = st; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == prev) @(negedge clk);
        if (e.hit) begin
            a = base[12:0] | e.off[12:0];
            chk("R7 byte at offset 6", 32'(mem[a + 13'd6]), 32'(e.b6));
            chk("R8 byte at offset 7", 32'(mem[a + 13'd7]), 32'(e.b7));
        end
        @(negedge clk);
        chk("R12 ready after response", 32'(req_ready), 32'd1);
        chk("R12 single pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : main
        logic [31:0] s, ea;
        rst = 1'b1; req_valid = 1'b0; req_store = 1'b0;
        req_segreg = '0; req_ea = '0;
        base = 32'h4000_0000; mask = 19'h0007F;
        clr();
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 32'(req_ready), 32'd1);
        chk("R1 no mem_req in reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);

        // R2 R7 R8: primary entry 0, store, R and C clear
        s = 32'h0000_0123; ea = 32'h1234_5000; clr();
        put(ent_addr(s, ea, 0, 0), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h0ABC_D002);
        run(s, ea, 1, 0);

        // R4 R5 R9: near misses before primary entry 5, load
        s = 32'h00AB_CDEF; ea = 32'h0FED_C000; clr();
        put(ent_addr(s, ea, 0, 1), mk_w0(1, s[23:0] ^ 24'h1, 0, ea[27:22]), 32'h0);
        put(ent_addr(s, ea, 0, 2), mk_w0(1, s[23:0], 1, ea[27:22]), 32'h0);
        put(ent_addr(s, ea, 0, 3), mk_w0(0, s[23:0], 0, ea[27:22]), 32'h0);
        put(ent_addr(s, ea, 0, 5), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h1111_1001);
        run(s, ea, 0, 2);

        // R3 R8: secondary hit at entry 3, store, R already set
        s = 32'h0055_AA55; ea = 32'h7654_3000; clr();
        put(ent_addr(s, ea, 0, 0), mk_w0(1, s[23:0], 1, ea[27:22]), 32'h0);
        put(ent_addr(s, ea, 1, 3), mk_w0(1, s[23:0], 1, ea[27:22]), 32'h2222_2100);
        run(s, ea, 1, 1);

        // R11: miss with wrong tag and wrong pass flag
        s = 32'h0001_0000; ea = 32'h0000_1000; clr();
        put(ent_addr(s, ea, 0, 4), mk_w0(1, s[23:0], 0, ea[27:22] ^ 6'h1), 32'h0);
        put(ent_addr(s, ea, 1, 6), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h0);
        run(s, ea, 1, 0);

        // R10: R and C already set, last primary entry
        s = 32'h0033_3333; ea = 32'h5555_5000; clr();
        put(ent_addr(s, ea, 0, 7), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h3333_3182);
        run(s, ea, 1, 3);

        // R5 R9: two matches, lower one wins; load with C set
        s = 32'h0012_3456; ea = 32'h3000_0000; clr();
        put(ent_addr(s, ea, 0, 2), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h4444_4080);
        put(ent_addr(s, ea, 0, 4), mk_w0(1, s[23:0], 0, ea[27:22]), 32'h5555_5000);
        run(s, ea, 0, 1);

        // R2 R3: narrow mask, secondary hit at entry 0, load
        mask = 19'h00003;
        s = 32'h0000_0F0F; ea = 32'h0ABC_D000; clr();
        put(ent_addr(s, ea, 1, 0), mk_w0(1, s[23:0], 1, ea[27:22]), 32'h0000_0000);
        run(s, ea, 0, 2);

        chk("R12 all responses seen", 32'(sb.size()), 32'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule